// File: doc/BRIEF.md
# 8-bit Step Arithmetic Flag Unit

This unit adds one to or subtracts one from an 8-bit operand and returns the wrapped result together with a recomputed flag byte. It sits beside an accumulator-style datapath: the caller presents the operand, a direction select and the current flag byte, pulses a start strobe, and one clock later reads the result, the new flags and a done pulse. The unit also reports the cycle cost that a register-operand step costs, so a sequencer can account for time without decoding the operation itself.

Flags are worked out from the result pattern rather than from an adder carry chain. Overflow is recognised by the two wrap values, half-carry by the low nibble, and the carry bit is copied through unchanged. The subtract indicator is always cleared, in both directions.

Top module: `step_flag_unit`

## Requirements
- R1: After reset the flag output and result output are 0x00 and the done output is low.
- R2: The result equals operand+1 modulo 256 when the direction input is 1, and operand+0xFF modulo 256 (that is, operand−1) when it is 0; 0xFF steps up to 0x00 and 0x00 steps down to 0xFF.
- R3: Flag bit 2 (overflow) is 1 exactly when an increment yields 0x80 or a decrement yields 0x7F.
- R4: Flag bit 4 (half-carry) is 1 exactly when an increment result has low nibble 0x0 or a decrement result has low nibble 0xF.
- R5: Flag bit 0 (carry) equals bit 0 of the incoming flag byte sampled with the start strobe.
- R6: Flag bit 1 (subtract) is 0 after every operation, including decrements and incoming flag bytes with bit 1 set.
- R7: Flag bit 7 equals result bit 7, bit 6 is 1 exactly when the result is 0x00, bit 5 equals result bit 5 and bit 3 equals result bit 3.
- R8: Result, flags and done change exactly one clock edge after a strobed input; done is high for one cycle per strobe and the outputs hold their values while the strobe is low.
- R9: The cost output is the parameter COST_CYC (default 4) whenever done is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand strobe |
| up | input | 1 | 1 = increment, 0 = decrement |
| opnd | input | 8 | Operand |
| flags_in | input | 8 | Current flag byte |
| res | output | 8 | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| done | output | 1 | One-cycle pulse, result valid |
| cost | output | 4 | Reported cycle cost while done |

## Verification
The bench builds the unit with its default widths: an 8-bit operand and a cost of 4 on a 4-bit field. At these values every operand can be stepped in both directions, so the bench sweeps all 512 combinations and compares each result and flag byte with a model built from the requirements, reaching both wrap points, both overflow values and every nibble boundary. Directed scenarios add reset state, carry pass-through with both carry values, a set subtract bit on input, and idle cycles in which the outputs must hold.

// File: rtl/step_flag_pkg.sv
package step_flag_pkg;
  localparam int unsigned DW = 8;

  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_N  = 1;
  localparam int unsigned FB_PV = 2;
  localparam int unsigned FB_X3 = 3;
  localparam int unsigned FB_H  = 4;
  localparam int unsigned FB_X5 = 5;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_S  = 7;

  typedef struct packed {
    logic [DW-1:0] val;
    logic [7:0]    fl;
  } step_out_t;
endpackage

// File: rtl/step_adder.sv
module step_adder #(
  parameter int unsigned W = 8
) (
  input  logic         up,
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W-1:0] addend;

  always_comb begin
    addend = up ? ONE : ALL1;
    y      = a + addend;
  end
endmodule

// File: rtl/step_flag_calc.sv
module step_flag_calc
  import step_flag_pkg::*;
(
  input  logic       up,
  input  logic [7:0] y,
  input  logic [7:0] fin,
  output logic [7:0] fout
);
  localparam logic [7:0] OV_UP = 8'h80;
  localparam logic [7:0] OV_DN = 8'h7F;
  localparam logic [3:0] HN_UP = 4'h0;
  localparam logic [3:0] HN_DN = 4'hF;

  logic ov, hc;

  always_comb begin
    ov = up ? (y == OV_UP) : (y == OV_DN);
    hc = up ? (y[3:0] == HN_UP) : (y[3:0] == HN_DN);
    fout        = '0;
    fout[FB_S]  = y[7];
    fout[FB_Z]  = (y == 8'h00);
    fout[FB_X5] = y[5];
    fout[FB_H]  = hc;
    fout[FB_X3] = y[3];
    fout[FB_PV] = ov;
    fout[FB_N]  = 1'b0;
    fout[FB_C]  = fin[FB_C];
  end
endmodule

// File: rtl/step_flag_unit.sv
module step_flag_unit
  import step_flag_pkg::*;
#(
  parameter int unsigned COST_CYC = 4,
  parameter int unsigned CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          up,
  input  logic [DW-1:0] opnd,
  input  logic [7:0]    flags_in,
  output logic [DW-1:0] res,
  output logic [7:0]    flags_out,
  output logic          done,
  output logic [CW-1:0] cost
);
  localparam logic [CW-1:0] COST_V = CW'(COST_CYC);

  logic [DW-1:0] sum;
  logic [7:0]    fnew;
  step_out_t     q_d, q_r;
  logic          done_d, done_r;

  step_adder #(.W(DW)) u_add (.up(up), .a(opnd), .y(sum));
  step_flag_calc u_fl (.up(up), .y(sum), .fin(flags_in), .fout(fnew));

  always_comb begin
    q_d    = q_r;
    done_d = start;
    if (start) begin
      q_d.val = sum;
      q_d.fl  = fnew;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      done_r <= 1'b0;
    end else begin
      q_r    <= q_d;
      done_r <= done_d;
    end
  end

  assign res       = q_r.val;
  assign flags_out = q_r.fl;
  assign done      = done_r;
  assign cost      = done_r ? COST_V : '0;

  p_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res == ($past(up) ? $past(opnd) + DW'(1) : $past(opnd) - DW'(1)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[FB_PV] == ((res == 8'h80 && $past(up)) || (res == 8'h7F && !$past(up))));
  p_carry_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> flags_out[FB_C] == $past(flags_in[FB_C]));
  p_sub_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_out[FB_N]);
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[FB_Z] == (res == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(res) && $stable(flags_out) && !done);
  p_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cost == COST_V);
endmodule

// File: tb/step_flag_unit_test.sv
`timescale 1ns/1ps
module step_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       up = 1'b0;
  logic [7:0] opnd = '0;
  logic [7:0] flags_in = '0;
  logic [7:0] res, flags_out;
  logic       done;
  logic [3:0] cost;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  step_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .up(up), .opnd(opnd),
    .flags_in(flags_in), .res(res), .flags_out(flags_out), .done(done), .cost(cost)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_res(input logic u, input logic [7:0] a);
    return u ? a + 8'd1 : a - 8'd1;
  endfunction

  function automatic logic [7:0] m_fl(input logic u, input logic [7:0] a, input logic [7:0] fi);
    logic [7:0] y, f;
    y = m_res(u, a);
    f = '0;
    f[7] = y[7];
    f[6] = (y == 0);
    f[5] = y[5];
    f[4] = u ? (y[3:0] == 4'h0) : (y[3:0] == 4'hF);
    f[3] = y[3];
    f[2] = u ? (y == 8'h80) : (y == 8'h7F);
    f[1] = 1'b0;
    f[0] = fi[0];
    return f;
  endfunction

  // drive one strobe, sample after the next edge
  task automatic step(input logic u, input logic [7:0] a, input logic [7:0] fi);
    @(negedge clk);
    up = u; opnd = a; flags_in = fi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 res", res, 0);
    chk("R1 flags", flags_out, 0);
    chk("R1 done", done, 0);
    chk("R9 idle cost", cost, 0);
  endtask

  task automatic t_sweep;
    int bad = 0;
    for (int d = 0; d < 2; d++)
      for (int v = 0; v < 256; v++) begin
        step(d[0], v[7:0], 8'h00);
        if (res !== m_res(d[0], v[7:0]) || flags_out !== m_fl(d[0], v[7:0], 8'h00)) begin
          bad++;
          $display("FAIL R2/R3/R4/R7 op=%0h up=%0d actual=%0h/%0h expected=%0h/%0h", v, d,
                   res, flags_out, m_res(d[0], v[7:0]), m_fl(d[0], v[7:0], 8'h00));
        end
      end
    checks++;
    if (bad != 0) errs++;
  endtask

  task automatic t_corners;
    step(1'b1, 8'hFF, 8'h00);
    chk("R2 wrap up", res, 8'h00);
    chk("R7 zero", flags_out[6], 1);
    chk("R4 hc up", flags_out[4], 1);
    step(1'b0, 8'h00, 8'h00);
    chk("R2 wrap dn", res, 8'hFF);
    chk("R4 hc dn", flags_out[4], 1);
    step(1'b1, 8'h7F, 8'h00);
    chk("R3 ov up", flags_out[2], 1);
    chk("R7 sign", flags_out[7], 1);
    step(1'b0, 8'h80, 8'h00);
    chk("R3 ov dn", flags_out[2], 1);
    step(1'b0, 8'h81, 8'h00);
    chk("R3 no ov", flags_out[2], 0);
  endtask

  task automatic t_carry_sub;
    step(1'b1, 8'h10, 8'h03);
    chk("R5 carry1", flags_out[0], 1);
    chk("R6 sub up", flags_out[1], 0);
    step(1'b0, 8'h10, 8'hFF);
    chk("R5 carry1 dn", flags_out[0], 1);
    chk("R6 sub dn", flags_out[1], 0);
    step(1'b0, 8'hFF, 8'hFE);
    chk("R5 carry0", flags_out[0], 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    up = 1'b1; opnd = 8'h41; flags_in = 8'h01; start = 1'b1;
    chk("R8 before edge", res, 8'h00);
    @(negedge clk);
    start = 1'b0;
    chk("R8 after edge", res, 8'h42);
    chk("R8 done", done, 1);
    chk("R9 cost", cost, 4);
    opnd = 8'h99; up = 1'b0; flags_in = 8'h00;
    @(negedge clk);
    chk("R8 done low", done, 0);
    chk("R8 hold res", res, 8'h42);
    chk("R8 hold flags", flags_out, m_fl(1'b1, 8'h41, 8'h01));
    chk("R9 cost idle", cost, 0);
  endtask

  initial begin
    fork
      begin
        #100_000_000;
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
      begin
        #5;
        t_reset;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset value of res is 0 for the timing test
        t_timing;
        t_corners;
        t_carry_sub;
        t_sweep;
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule